// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment:offset pair into a 20-bit physical address. It holds no segment state of its own. Each cycle it takes the four 16-bit segment register values, a 16-bit offset, a 3-bit access-kind code and the byte that came before the instruction. From these it picks one segment, appends four zero bits to that segment, adds the offset, and registers the result.

The access kind decides the default segment. If the preceding byte has the form of a segment-override prefix, it can replace that default. Code fetches, stack pointer accesses and string destinations never take an override. Any byte that does not have the prefix form is ignored. The output register gives a fixed latency of one cycle. When no request is presented, the last result is held.

Top module: `seg_phys_addr_gen`

## Requirements
- R1: The address is (segment << 4) + offset. Segment 348AH with offset 4214H gives 38AB4H.
- R2: A sum that carries past bit 19 wraps modulo 2^20. Segment FFFFH with offset FFFFH gives 0FFEFH.
- R3: Access code 0 (code fetch) always selects the code segment, whatever the prefix byte holds.
- R4: Access code 1 (stack pointer access) always selects the stack segment, whatever the prefix byte holds.
- R5: Access code 4 (string destination) always selects the extra segment, whatever the prefix byte holds.
- R6: With no override, access code 2 (base-pointer data) selects the stack segment. Codes 3, 5, 6 and 7 (general and source-index data) select the data segment.
- R7: For codes 2, 3, 5, 6 and 7, a prefix byte matching 001XX110 selects the segment named by bits 4:3: ES=00, CS=01, SS=10, DS=11.
- R8: A prefix byte that does not match 001XX110 has no effect, and the default segment of R6 applies.
- R9: A request with req_valid_i high shows its address and segment on the outputs after the next rising clock edge, with addr_valid_o high. In a cycle without a request, addr_valid_o is low and phys_addr_o and seg_sel_o hold their values.
- R10: While reset is asserted, addr_valid_o is 0, phys_addr_o is 0 and seg_sel_o is 0.
- R11: seg_sel_o reports the segment used, encoded ES=0, CS=1, SS=2, DS=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| acc_kind_i | input | 3 | Access-kind code |
| prefix_i | input | 8 | Byte preceding the instruction |
| seg_es_i | input | 16 | Extra segment value |
| seg_cs_i | input | 16 | Code segment value |
| seg_ss_i | input | 16 | Stack segment value |
| seg_ds_i | input | 16 | Data segment value |
| offset_i | input | 16 | Offset within the segment |
| addr_valid_o | output | 1 | Registered result valid |
| phys_addr_o | output | 20 | Physical address |
| seg_sel_o | output | 2 | Segment used |

## Verification
The four segment values are kept distinct and random, so a wrong segment choice shows up as a wrong address and a wrong seg_sel_o. Every access code is run with each of the four override prefixes. This separates the codes that honour an override from the three that must ignore it. Bytes next to the prefix pattern, with one fixed bit flipped, confirm that the mask is exact and not loose. Fixed vectors cover the worked example and the carry out of bit 19. Idle cycles between requests show whether the outputs hold their values.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int unsigned SEG_W   = 16;
  localparam int unsigned OFF_W   = 16;
  localparam int unsigned ADDR_W  = 20;
  localparam int unsigned SHIFT   = 4;
  localparam int unsigned NUM_SEG = 4;
  localparam int unsigned SEL_W   = $clog2(NUM_SEG);
  localparam int unsigned KIND_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_id_e;

  localparam logic [KIND_W-1:0] KIND_FETCH   = 3'd0;
  localparam logic [KIND_W-1:0] KIND_STACK   = 3'd1;
  localparam logic [KIND_W-1:0] KIND_BP      = 3'd2;
  localparam logic [KIND_W-1:0] KIND_DATA    = 3'd3;
  localparam logic [KIND_W-1:0] KIND_STR_DST = 3'd4;

  localparam logic [7:0] PFX_MASK  = 8'b1110_0111;
  localparam logic [7:0] PFX_MATCH = 8'b0010_0110;
  localparam int unsigned PFX_SEL_LSB = 3;
endpackage

// File: rtl/seg_prefix_dec.sv
module seg_prefix_dec
  import seg_addr_pkg::*;
(
  input  logic [7:0] byte_i,
  output logic       hit_o,
  output seg_id_e    sel_o
);
  assign hit_o = (byte_i & PFX_MASK) == PFX_MATCH;
  assign sel_o = seg_id_e'(byte_i[PFX_SEL_LSB +: SEL_W]);
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
(
  input  logic [KIND_W-1:0]             kind_i,
  input  logic                          ovr_hit_i,
  input  seg_id_e                       ovr_sel_i,
  input  logic [NUM_SEG-1:0][SEG_W-1:0] seg_bank_i,
  output seg_id_e                       sel_o,
  output logic [SEG_W-1:0]              seg_o
);
  seg_id_e dflt_sel;
  logic    locked;

  always_comb begin
    locked = 1'b0;
    unique case (kind_i)
      KIND_FETCH:   begin dflt_sel = SEG_CS; locked = 1'b1; end
      KIND_STACK:   begin dflt_sel = SEG_SS; locked = 1'b1; end
      KIND_STR_DST: begin dflt_sel = SEG_ES; locked = 1'b1; end
      KIND_BP:      dflt_sel = SEG_SS;
      default:      dflt_sel = SEG_DS;
    endcase
  end

  assign sel_o = (ovr_hit_i && !locked) ? ovr_sel_i : dflt_sel;
  assign seg_o = seg_bank_i[sel_o];
endmodule

// File: rtl/seg_addr_add.sv
module seg_addr_add #(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned SHIFT  = 4
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] off_ext;

  // truncation to ADDR_W gives the modulo wrap
  assign base    = ADDR_W'(seg_i) << SHIFT;
  assign off_ext = ADDR_W'(off_i);
  assign addr_o  = base + off_ext;
endmodule

// File: rtl/seg_phys_addr_gen.sv
module seg_phys_addr_gen
  import seg_addr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        acc_kind_i,
  input  logic [7:0]        prefix_i,
  input  logic [15:0]       seg_es_i,
  input  logic [15:0]       seg_cs_i,
  input  logic [15:0]       seg_ss_i,
  input  logic [15:0]       seg_ds_i,
  input  logic [15:0]       offset_i,
  output logic              addr_valid_o,
  output logic [19:0]       phys_addr_o,
  output logic [1:0]        seg_sel_o
);
  logic [NUM_SEG-1:0][SEG_W-1:0] seg_bank;
  logic              pfx_hit;
  seg_id_e           pfx_sel;
  seg_id_e           sel;
  logic [SEG_W-1:0]  seg_val;
  logic [ADDR_W-1:0] addr_d;

  assign seg_bank[SEG_ES] = seg_es_i;
  assign seg_bank[SEG_CS] = seg_cs_i;
  assign seg_bank[SEG_SS] = seg_ss_i;
  assign seg_bank[SEG_DS] = seg_ds_i;

  seg_prefix_dec u_pfx (
    .byte_i (prefix_i),
    .hit_o  (pfx_hit),
    .sel_o  (pfx_sel)
  );

  seg_select u_sel (
    .kind_i     (acc_kind_i),
    .ovr_hit_i  (pfx_hit),
    .ovr_sel_i  (pfx_sel),
    .seg_bank_i (seg_bank),
    .sel_o      (sel),
    .seg_o      (seg_val)
  );

  seg_addr_add #(
    .SEG_W (SEG_W), .OFF_W (OFF_W), .ADDR_W (ADDR_W), .SHIFT (SHIFT)
  ) u_add (
    .seg_i  (seg_val),
    .off_i  (offset_i),
    .addr_o (addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_valid_o <= 1'b0;
      phys_addr_o  <= '0;
      seg_sel_o    <= '0;
    end else begin
      addr_valid_o <= req_valid_i;
      if (req_valid_i) begin
        phys_addr_o <= addr_d;
        seg_sel_o   <= sel;
      end
    end
  end

  AST_FETCH_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && acc_kind_i == KIND_FETCH |=> seg_sel_o == SEG_CS); // R3
  AST_STACK_SS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && acc_kind_i == KIND_STACK |=> seg_sel_o == SEG_SS); // R4
  AST_STR_DST_ES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && acc_kind_i == KIND_STR_DST |=> seg_sel_o == SEG_ES); // R5
  AST_OVR_HONOURED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && ((prefix_i & PFX_MASK) == PFX_MATCH) &&
    (acc_kind_i == KIND_BP || acc_kind_i == KIND_DATA || acc_kind_i > KIND_STR_DST)
    |=> seg_sel_o == $past(prefix_i[4:3])); // R7
  AST_VALID_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> addr_valid_o); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !addr_valid_o && $stable(phys_addr_o) && $stable(seg_sel_o)); // R9
endmodule

// File: tb/seg_phys_addr_gen_bench.sv
module seg_phys_addr_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  acc_kind = '0;
  logic [7:0]  prefix = '0;
  logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
  logic [15:0] offset = '0;
  logic        addr_valid;
  logic [19:0] phys_addr;
  logic [1:0]  seg_sel;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  int exp_addr = 0;
  int exp_sel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_phys_addr_gen u_seg_phys_addr_gen (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid),
    .acc_kind_i   (acc_kind),
    .prefix_i     (prefix),
    .seg_es_i     (seg_es),
    .seg_cs_i     (seg_cs),
    .seg_ss_i     (seg_ss),
    .seg_ds_i     (seg_ds),
    .offset_i     (offset),
    .addr_valid_o (addr_valid),
    .phys_addr_o  (phys_addr),
    .seg_sel_o    (seg_sel)
  );

  function automatic bit is_prefix(input int b);
    return ((b >> 5) == 1) && ((b % 8) == 6);
  endfunction

  function automatic int model_sel(input int kind, input int b);
    if (kind == 0) return 1;
    if (kind == 1) return 2;
    if (kind == 4) return 0;
    if (is_prefix(b)) return (b / 8) % 4;
    if (kind == 2) return 2;
    return 3;
  endfunction

  function automatic string tag_of(input int kind, input int b);
    if (kind == 0) return "R3";
    if (kind == 1) return "R4";
    if (kind == 4) return "R5";
    if (is_prefix(b)) return "R7";
    if (b != 0) return "R8";
    return "R6";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic request(input int kind, input int b, input int off, input string atag);
    int seg_v;
    int sel_v;
    @(negedge clk);
    req_valid = 1'b1;
    acc_kind = 3'(kind);
    prefix = 8'(b);
    offset = 16'(off);
    sel_v = model_sel(kind, b);
    case (sel_v)
      0: seg_v = int'(seg_es);
      1: seg_v = int'(seg_cs);
      2: seg_v = int'(seg_ss);
      default: seg_v = int'(seg_ds);
    endcase
    exp_addr = (seg_v * 16 + off) % (1 << 20);
    exp_sel = sel_v;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9", int'(addr_valid), 1);
    check(atag, int'(phys_addr), exp_addr);
    check({tag_of(kind, b), "/R11"}, int'(seg_sel), exp_sel);
  endtask

  task automatic idle_check();
    @(negedge clk);
    req_valid = 1'b0;
    acc_kind = 3'(acc_kind + 1);
    offset = offset ^ 16'hA5A5;
    @(negedge clk);
    check("R9", int'(addr_valid), 0);
    check("R9", int'(phys_addr), exp_addr);
    check("R9", int'(seg_sel), exp_sel);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", int'(addr_valid), 0);
    check("R10", int'(phys_addr), 0);
    check("R10", int'(seg_sel), 0);
    rst_n = 1'b1;

    // R1 worked example through the data segment
    seg_ds = 16'h348A; seg_es = 16'h1111; seg_cs = 16'h2222; seg_ss = 16'h3333;
    request(3, 8'h00, 16'h4214, "R1");
    check("R1", int'(phys_addr), 20'h38AB4);
    // R2 carry out of bit 19
    seg_ds = 16'hFFFF;
    request(3, 8'h00, 16'hFFFF, "R2");
    check("R2", int'(phys_addr), 20'h0FFEF);
    idle_check();

    for (int rep = 0; rep < 6; rep++) begin
      seg_es = 16'($urandom); seg_cs = 16'($urandom);
      seg_ss = 16'($urandom); seg_ds = 16'($urandom);
      for (int k = 0; k < 8; k++) begin
        request(k, 8'h00, int'($urandom % 65536), "R1");
        for (int s = 0; s < 4; s++)
          request(k, 8'h26 | (s << 3), int'($urandom % 65536), "R1");
        // near-miss bytes: one fixed bit flipped
        for (int f = 0; f < 8; f++)
          if (f != 3 && f != 4)
            request(k, 8'h36 ^ (1 << f), int'($urandom % 65536), "R8");
        if (k == 3) idle_check();
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule